// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block holds the per-line interrupt state of a small multi-processor interrupt controller and forwards pending, enabled lines to each processor's interface. Software reaches it through a 32-bit word-addressed register bus. Every request names the processor that makes it, so the first 32 lines can keep a private copy of their enable and pending state per processor. Lines 32 and up are shared. Each shared line carries an 8-bit routing field with one bit per processor.

Each line also has an 8-bit priority field and a trigger mode, either rising edge or level high. A global forward switch gates every output. The block stores priorities and returns them on reads, but it does not rank lines; selection and acknowledge are the job of the processor interface. Each processor gets one registered request output, high while any line is enabled, pending and routed to it.

The word address is split into a 4-bit region (bits 9:6) and a 6-bit index (bits 5:0). The regions are: 0 control/type, 1 enable set, 2 enable clear, 3 pending set, 4 pending clear, 5 priority, 6 routing, 7 trigger mode.

Top module: `idist_regbank`

## Requirements
- R1: After reset the following are all zero: every enable, pending latch, priority, routing field, edge bit, the forward switch, `cpu_irq` and `bus_rvalid`.
- R2: A read presents its data on `bus_rdata` with `bus_rvalid` high exactly one clock after the request. `bus_rvalid` is low after any cycle without a read.
- R3: Enable words pack 32 lines each: index k, bit b is line 32k+b. Writing 1 to a bit in the enable-set region enables that line. Writing 1 in the enable-clear region disables it. Zero bits change nothing. Both regions read back the current enables.
- R4: Trigger-mode words pack 16 lines each: index k, bits 2j+1:2j are line 16k+j. Bit 2j+1 is 1 for rising edge and 0 for level high; bit 2j reads 0. Lines 0 to 15 always read as binary 10, and writes to them are dropped.
- R5: Priority words pack four lines: index k, byte j (bits 8j+7:8j) is line 4k+j. Every byte reads back as written.
- R6: Routing words pack four 8-bit fields in the same layout as R5. For lines 32 and up, the low NUM_CPU bits of a field are stored and the upper bits read zero. For lines 0 to 31, a read returns the requesting processor's one-hot mask (1 shifted left by `bus_cpu`) and writes are dropped.
- R7: Control index 1 reads NUM_IRQ/32-1 in bits 4:0 and zero elsewhere. It ignores writes.
- R8: Control index 0, bit 0, is the forward switch. While it is 0, every `cpu_irq` bit is 0 one clock later, and the pending state is kept.
- R9: A rising-edge line latches pending on a rising input and holds it until a 1 is written to its bit in the pending-clear region. A level line is pending while its input is high. A 1 written in the pending-set region latches pending. Both pending regions read the current pending state, using the layout of R3.
- R10: If a rising input edge and a pending-clear write for the same line take effect in the same clock, the line stays pending.
- R11: Lines 0 to 31 keep separate enable and pending state per processor. Processor c's copy is fed by `local_irq[32c+i]`, and register accesses use the copy selected by `bus_cpu`.
- R12: `cpu_irq[c]` is a register. It goes high within two clocks of any line being enabled, pending and routed to c (lines 0 to 31 of bank c always route to c) while the forward switch is 1. It goes low within two clocks once no such line remains.
- R13: Regions 8 to 15, control indices above 1, and indices beyond a region's word count read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Register request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_cpu | input | CPU_W | Processor issuing the request |
| bus_addr | input | 10 | Word address: region in bits 9:6, index in bits 5:0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data strobe, one clock after a read |
| shared_irq | input | NUM_IRQ-32 | Inputs of lines 32 and up (bit i is line 32+i) |
| local_irq | input | NUM_CPU*32 | Private inputs of lines 0 to 31, one group of 32 per processor |
| cpu_irq | output | NUM_CPU | Registered request per processor |

## Verification
The sharp collision is an input edge landing in the same clock as a software clear of that line's pending latch. The bench sets up the clash by raising the edge-mode line's input on the same falling edge that presents the pending-clear write, so both act at one rising edge. It then reads the pending region and expects the line still set. A second clear, with no edge, must drop the line, which proves the clear path itself works. A related overlap is the forward switch turning off while a line is pending. That case is judged by `cpu_irq` falling while the pending read still shows the line.

// File: rtl/idist_pkg.sv
package idist_pkg;
  localparam int unsigned ADDR_W = 10;
  localparam int unsigned RGN_W  = 4;
  localparam int unsigned IDX_W  = 6;

  typedef enum logic [RGN_W-1:0] {
    RG_CTRL  = 4'd0,
    RG_ENSET = 4'd1,
    RG_ENCLR = 4'd2,
    RG_PDSET = 4'd3,
    RG_PDCLR = 4'd4,
    RG_PRIO  = 4'd5,
    RG_TGT   = 4'd6,
    RG_CFG   = 4'd7
  } region_e;

  // one flag per implemented register group, at most one set per access
  typedef struct packed {
    logic ctrl;
    logic typ;
    logic enset;
    logic enclr;
    logic pdset;
    logic pdclr;
    logic prio;
    logic tgt;
    logic cfg;
  } hit_t;
endpackage

// File: rtl/idist_decode.sv
module idist_decode
  import idist_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64
) (
  input  logic [ADDR_W-1:0] addr,
  output hit_t              hit,
  output logic [IDX_W-1:0]  idx
);
  localparam int unsigned EN_WORDS  = NUM_IRQ / 32;
  localparam int unsigned PRI_WORDS = NUM_IRQ / 4;
  localparam int unsigned CFG_WORDS = NUM_IRQ / 16;

  logic [RGN_W-1:0] rgn;
  assign rgn = addr[ADDR_W-1 -: RGN_W];
  assign idx = addr[IDX_W-1:0];

  always_comb begin
    hit = '0;
    case (rgn)
      RG_CTRL: begin
        hit.ctrl = (idx == IDX_W'(0));
        hit.typ  = (idx == IDX_W'(1));
      end
      RG_ENSET: hit.enset = (32'(idx) < EN_WORDS);
      RG_ENCLR: hit.enclr = (32'(idx) < EN_WORDS);
      RG_PDSET: hit.pdset = (32'(idx) < EN_WORDS);
      RG_PDCLR: hit.pdclr = (32'(idx) < EN_WORDS);
      RG_PRIO:  hit.prio  = (32'(idx) < PRI_WORDS);
      RG_TGT:   hit.tgt   = (32'(idx) < PRI_WORDS);
      RG_CFG:   hit.cfg   = (32'(idx) < CFG_WORDS);
      default:  hit = '0;
    endcase
  end
endmodule

// File: rtl/idist_lines.sv
module idist_lines #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] line_in,
  input  logic [W-1:0] edge_mode,
  input  logic [W-1:0] en_set,
  input  logic [W-1:0] en_clr,
  input  logic [W-1:0] pd_set,
  input  logic [W-1:0] pd_clr,
  output logic [W-1:0] en_q,
  output logic [W-1:0] pending
);
  logic [W-1:0] prev_q;
  logic [W-1:0] latch_q, latch_d;
  logic [W-1:0] en_d;
  logic [W-1:0] rise;
  logic         en_upd;

  always_comb begin
    rise    = line_in & ~prev_q;
    // a fresh edge outranks a clear landing in the same clock
    latch_d = (latch_q & ~pd_clr) | pd_set | (edge_mode & rise);
    en_d    = (en_q & ~en_clr) | en_set;
    en_upd  = |(en_set | en_clr);
    pending = latch_q | (~edge_mode & line_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      latch_q <= '0;
      en_q    <= '0;
    end else begin
      prev_q  <= line_in;
      latch_q <= latch_d;
      if (en_upd) en_q <= en_d;
    end
  end
endmodule

// File: rtl/idist_route.sv
module idist_route #(
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned NUM_CPU = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            fwd_en,
  input  logic [NUM_CPU-1:0][NUM_IRQ-1:0] en_view,
  input  logic [NUM_CPU-1:0][NUM_IRQ-1:0] pd_view,
  input  logic [NUM_CPU-1:0][NUM_IRQ-1:0] tgt_mask,
  output logic [NUM_CPU-1:0]              cpu_irq
);
  logic [NUM_CPU-1:0] irq_d;

  always_comb begin
    for (int c = 0; c < NUM_CPU; c++) begin
      irq_d[c] = fwd_en & (|(en_view[c] & pd_view[c] & tgt_mask[c]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpu_irq <= '0;
    else        cpu_irq <= irq_d;
  end
endmodule

// File: rtl/idist_regbank.sv
module idist_regbank
  import idist_pkg::*;
#(
  parameter  int unsigned NUM_IRQ = 64,
  parameter  int unsigned NUM_CPU = 2,
  localparam int unsigned CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_valid,
  input  logic                    bus_write,
  input  logic [CPU_W-1:0]        bus_cpu,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic                    bus_rvalid,
  input  logic [NUM_IRQ-33:0]     shared_irq,
  input  logic [NUM_CPU*32-1:0]   local_irq,
  output logic [NUM_CPU-1:0]      cpu_irq
);
  localparam int unsigned SHARED    = NUM_IRQ - 32;
  localparam int unsigned EN_WORDS  = NUM_IRQ / 32;
  localparam int unsigned PRI_WORDS = NUM_IRQ / 4;
  localparam logic [31:0] TYPE_WORD = 32'(NUM_IRQ / 32 - 1);

  // reset: asserted at once, removed on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  hit_t             hit;
  logic [IDX_W-1:0] idx;
  logic             wr_go, rd_go;

  idist_decode #(.NUM_IRQ(NUM_IRQ)) u_dec (
    .addr(bus_addr), .hit(hit), .idx(idx)
  );

  assign wr_go = bus_valid & bus_write;
  assign rd_go = bus_valid & ~bus_write;

  // configuration storage
  logic                            ctrl_q, ctrl_d;
  logic [NUM_IRQ-1:0][7:0]         pri_q, pri_d;
  logic [SHARED-1:0][NUM_CPU-1:0]  tgt_q, tgt_d;
  logic [NUM_IRQ-1:16]             cfg_q, cfg_d;
  logic [NUM_IRQ-1:0]              edge_mode;

  always_comb begin
    edge_mode                = '1;
    edge_mode[NUM_IRQ-1:16]  = cfg_q;
  end

  // shared-line state
  logic [SHARED-1:0] sh_en_set, sh_en_clr, sh_pd_set, sh_pd_clr;
  logic [SHARED-1:0] sh_en, sh_pd;

  always_comb begin
    for (int i = 0; i < SHARED; i++) begin
      sh_en_set[i] = wr_go & hit.enset & (int'(idx) == (i + 32) / 32) & bus_wdata[i % 32];
      sh_en_clr[i] = wr_go & hit.enclr & (int'(idx) == (i + 32) / 32) & bus_wdata[i % 32];
      sh_pd_set[i] = wr_go & hit.pdset & (int'(idx) == (i + 32) / 32) & bus_wdata[i % 32];
      sh_pd_clr[i] = wr_go & hit.pdclr & (int'(idx) == (i + 32) / 32) & bus_wdata[i % 32];
    end
  end

  idist_lines #(.W(SHARED)) u_shared (
    .clk(clk), .rst_n(rst_sync_n),
    .line_in(shared_irq), .edge_mode(edge_mode[NUM_IRQ-1:32]),
    .en_set(sh_en_set), .en_clr(sh_en_clr),
    .pd_set(sh_pd_set), .pd_clr(sh_pd_clr),
    .en_q(sh_en), .pending(sh_pd)
  );

  // private-line state, one copy per processor
  logic [31:0] bk_en_set [NUM_CPU];
  logic [31:0] bk_en_clr [NUM_CPU];
  logic [31:0] bk_pd_set [NUM_CPU];
  logic [31:0] bk_pd_clr [NUM_CPU];
  logic [31:0] bk_en     [NUM_CPU];
  logic [31:0] bk_pd     [NUM_CPU];

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
    logic own;
    assign own          = wr_go & (idx == IDX_W'(0)) & (bus_cpu == CPU_W'(c));
    assign bk_en_set[c] = {32{own & hit.enset}} & bus_wdata;
    assign bk_en_clr[c] = {32{own & hit.enclr}} & bus_wdata;
    assign bk_pd_set[c] = {32{own & hit.pdset}} & bus_wdata;
    assign bk_pd_clr[c] = {32{own & hit.pdclr}} & bus_wdata;

    idist_lines #(.W(32)) u_bank (
      .clk(clk), .rst_n(rst_sync_n),
      .line_in(local_irq[c*32 +: 32]), .edge_mode(edge_mode[31:0]),
      .en_set(bk_en_set[c]), .en_clr(bk_en_clr[c]),
      .pd_set(bk_pd_set[c]), .pd_clr(bk_pd_clr[c]),
      .en_q(bk_en[c]), .pending(bk_pd[c])
    );
  end

  // per-processor views of the whole line space
  logic [NUM_CPU-1:0][NUM_IRQ-1:0] en_view, pd_view, tgt_mask;

  always_comb begin
    for (int c = 0; c < NUM_CPU; c++) begin
      en_view[c] = {sh_en, bk_en[c]};
      pd_view[c] = {sh_pd, bk_pd[c]};
      tgt_mask[c][31:0] = '1;
      for (int i = 0; i < SHARED; i++) tgt_mask[c][i+32] = tgt_q[i][c];
    end
  end

  idist_route #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_route (
    .clk(clk), .rst_n(rst_sync_n), .fwd_en(ctrl_q),
    .en_view(en_view), .pd_view(pd_view), .tgt_mask(tgt_mask),
    .cpu_irq(cpu_irq)
  );

  // next state of the configuration fields
  always_comb begin
    ctrl_d = bus_wdata[0];
    pri_d  = pri_q;
    for (int i = 0; i < NUM_IRQ; i++)
      if (int'(idx) == i / 4) pri_d[i] = bus_wdata[(i % 4) * 8 +: 8];
    tgt_d = tgt_q;
    for (int i = 0; i < SHARED; i++)
      if (int'(idx) == (i + 32) / 4) tgt_d[i] = bus_wdata[((i + 32) % 4) * 8 +: NUM_CPU];
    cfg_d = cfg_q;
    for (int i = 16; i < NUM_IRQ; i++)
      if (int'(idx) == i / 16) cfg_d[i] = bus_wdata[(i % 16) * 2 + 1];
  end

  // read data selection
  logic [31:0]        rd_word;
  logic [7:0]         own_mask;
  logic [NUM_IRQ-1:0] en_sel, pd_sel;
  logic [31:0]        rdata_q;
  logic               rvalid_q;

  always_comb begin
    en_sel   = en_view[bus_cpu];
    pd_sel   = pd_view[bus_cpu];
    own_mask = 8'(1) << bus_cpu;
    rd_word  = '0;
    if (hit.ctrl) rd_word[0] = ctrl_q;
    if (hit.typ)  rd_word = TYPE_WORD;
    if (hit.enset | hit.enclr)
      for (int w = 0; w < EN_WORDS; w++)
        if (int'(idx) == w) rd_word = en_sel[w*32 +: 32];
    if (hit.pdset | hit.pdclr)
      for (int w = 0; w < EN_WORDS; w++)
        if (int'(idx) == w) rd_word = pd_sel[w*32 +: 32];
    if (hit.prio)
      for (int w = 0; w < PRI_WORDS; w++)
        if (int'(idx) == w) rd_word = pri_q[w*4 +: 4];
    if (hit.tgt) begin
      for (int i = 0; i < 32; i++)
        if (int'(idx) == i / 4) rd_word[(i % 4) * 8 +: 8] = own_mask;
      for (int i = 0; i < SHARED; i++)
        if (int'(idx) == (i + 32) / 4) rd_word[((i + 32) % 4) * 8 +: 8] = 8'(tgt_q[i]);
    end
    if (hit.cfg)
      for (int i = 0; i < NUM_IRQ; i++)
        if (int'(idx) == i / 16) rd_word[(i % 16) * 2 + 1] = edge_mode[i];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q   <= 1'b0;
      pri_q    <= '0;
      tgt_q    <= '0;
      cfg_q    <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (wr_go & hit.ctrl) ctrl_q <= ctrl_d;
      if (wr_go & hit.prio) pri_q  <= pri_d;
      if (wr_go & hit.tgt)  tgt_q  <= tgt_d;
      if (wr_go & hit.cfg)  cfg_q  <= cfg_d;
      if (rd_go)            rdata_q <= rd_word;
      rvalid_q <= rd_go;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
endmodule

// File: rtl/idist_checker.sv
module idist_checker #(
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned NUM_CPU = 2,
  parameter int unsigned CPU_W   = 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_valid,
  input logic               bus_write,
  input logic [CPU_W-1:0]   bus_cpu,
  input logic [9:0]         bus_addr,
  input logic [31:0]        bus_rdata,
  input logic               bus_rvalid,
  input logic [NUM_CPU-1:0] cpu_irq,
  input logic               fwd_en
);
  localparam logic [31:0] TYPE_WORD = 32'(NUM_IRQ / 32 - 1);
  logic rd_go;
  assign rd_go = bus_valid & ~bus_write;

  AST_FWD_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_en |=> (cpu_irq == '0)); // R8

  AST_RD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> bus_rvalid); // R2

  AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |=> !bus_rvalid); // R2

  AST_TYPE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && bus_addr == 10'd1) |=> (bus_rdata == TYPE_WORD)); // R7

  AST_SOFT_CFG_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && bus_addr == {4'd7, 6'd0}) |=> (bus_rdata == 32'hAAAA_AAAA)); // R4

  AST_OWN_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && bus_addr[9:6] == 4'd6 && bus_addr[5:0] < 6'd8)
      |=> (bus_rdata == {4{8'(8'(1) << $past(bus_cpu))}})); // R6

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && bus_addr[9:6] >= 4'd8) |=> (bus_rdata == '0)); // R13
endmodule

bind idist_regbank idist_checker #(
  .NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .CPU_W(CPU_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_cpu(bus_cpu), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .bus_rvalid(bus_rvalid), .cpu_irq(cpu_irq), .fwd_en(ctrl_q)
);

// File: tb/idist_regbank_test.sv
module idist_regbank_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_write;
  logic [0:0]  bus_cpu;
  logic [9:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_rvalid;
  logic [31:0] shared_irq;
  logic [63:0] local_irq;
  logic [1:0]  cpu_irq;

  int ntests = 0;
  int nfail  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  idist_regbank uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_cpu(bus_cpu), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .shared_irq(shared_irq), .local_irq(local_irq), .cpu_irq(cpu_irq)
  );

  logic [7:0]  m_pri [64];
  logic [63:0] m_en  [2];

  function automatic logic [9:0] adr(input int rg, input int ix);
    return 10'(rg * 64 + ix);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic c, input logic [9:0] a, input logic [31:0] d);
    bus_valid = 1; bus_write = 1; bus_cpu = c; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic bus_rd(input logic c, input logic [9:0] a, output logic [31:0] d);
    bus_valid = 1; bus_write = 0; bus_cpu = c; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, seed;
    seed = $urandom(32'd4711);
    rst_n = 0; bus_valid = 0; bus_write = 0; bus_cpu = 0; bus_addr = '0;
    bus_wdata = '0; shared_irq = '0; local_irq = '0;
    for (int i = 0; i < 64; i++) m_pri[i] = '0;
    m_en[0] = '0; m_en[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 cpu_irq", 32'(cpu_irq), 0);
    chk("R1 rvalid", 32'(bus_rvalid), 0);
    bus_rd(0, adr(0, 0), rd); chk("R1 control", rd, 0);
    chk("R2 rvalid after read", 32'(bus_rvalid), 1);
    bus_rd(1, adr(1, 1), rd); chk("R1 enables", rd, 0);
    bus_rd(0, adr(7, 2), rd); chk("R1 edge bits", rd, 0);
    bus_rd(0, adr(6, 9), rd); chk("R1 routing", rd, 0);
    @(negedge clk); chk("R2 rvalid idle", 32'(bus_rvalid), 0);

    // R7 type
    bus_rd(0, adr(0, 1), rd); chk("R7 type", rd, 32'd1);

    // R4 trigger mode
    bus_rd(0, adr(7, 0), rd); chk("R4 soft lines fixed", rd, 32'hAAAA_AAAA);
    bus_wr(0, adr(7, 0), 32'h0000_0000);
    bus_wr(0, adr(7, 1), 32'hFFFF_FFFF);
    bus_rd(0, adr(7, 0), rd); chk("R4 soft write ignored", rd, 32'hAAAA_AAAA);
    bus_rd(1, adr(7, 1), rd); chk("R4 edge bits only", rd, 32'hAAAA_AAAA);
    bus_wr(0, adr(7, 1), 32'h0);
    bus_rd(0, adr(7, 1), rd); chk("R4 back to level", rd, 0);

    // R5 priority, random
    for (int n = 0; n < 40; n++) begin
      int w; logic [31:0] d;
      w = int'($urandom % 16); d = $urandom;
      bus_wr(1'($urandom % 2), adr(5, w), d);
      for (int j = 0; j < 4; j++) m_pri[w*4+j] = d[j*8 +: 8];
    end
    bus_wr(0, adr(5, 0), 32'h00FF_7F80);
    for (int j = 0; j < 4; j++) m_pri[j] = 8'(32'h00FF_7F80 >> (8*j));
    for (int w = 0; w < 16; w++) begin
      bus_rd(1'(w % 2), adr(5, w), rd);
      chk("R5 priority word", rd, {m_pri[w*4+3], m_pri[w*4+2], m_pri[w*4+1], m_pri[w*4]});
    end

    // R3 / R11 enables, random set and clear
    for (int n = 0; n < 30; n++) begin
      int c, w; bit clr; logic [31:0] d;
      c = int'($urandom % 2); w = int'($urandom % 2); clr = 1'($urandom % 2);
      d = (n == 5) ? 32'h0 : $urandom;
      bus_wr(1'(c), adr(clr ? 2 : 1, w), d);
      if (w == 0) m_en[c][31:0] = clr ? (m_en[c][31:0] & ~d) : (m_en[c][31:0] | d);
      else for (int k = 0; k < 2; k++)
        m_en[k][63:32] = clr ? (m_en[k][63:32] & ~d) : (m_en[k][63:32] | d);
    end
    bus_wr(1, adr(2, 1), 32'h0);
    bus_wr(0, adr(1, 0), 32'h0);
    for (int c = 0; c < 2; c++)
      for (int w = 0; w < 2; w++) begin
        bus_rd(1'(c), adr(1, w), rd); chk("R3 set view R11 bank", rd, m_en[c][w*32 +: 32]);
        bus_rd(1'(c), adr(2, w), rd); chk("R3 clear view R11 bank", rd, m_en[c][w*32 +: 32]);
      end
    bus_wr(0, adr(2, 0), 32'hFFFF_FFFF);
    bus_wr(1, adr(2, 0), 32'hFFFF_FFFF);
    bus_wr(0, adr(2, 1), 32'hFFFF_FFFF);
    bus_rd(1, adr(1, 0), rd); chk("R3 clear all", rd, 0);

    // R6 routing
    bus_rd(1, adr(6, 3), rd); chk("R6 own mask cpu1", rd, 32'h0202_0202);
    bus_wr(0, adr(6, 7), 32'hFFFF_FFFF);
    bus_rd(0, adr(6, 7), rd); chk("R6 own mask write ignored", rd, 32'h0101_0101);
    bus_wr(0, adr(6, 9), 32'hFFFF_FFFF);
    bus_rd(1, adr(6, 9), rd); chk("R6 shared field width", rd, 32'h0303_0303);

    // R13 unmapped
    bus_wr(0, adr(8, 0), 32'hFFFF_FFFF);
    bus_rd(0, adr(8, 0), rd); chk("R13 region 8", rd, 0);
    bus_rd(0, adr(1, 5), rd); chk("R13 enable index", rd, 0);
    bus_wr(0, adr(5, 20), 32'h1234_5678);
    bus_rd(0, adr(5, 20), rd); chk("R13 priority index", rd, 0);
    bus_rd(0, adr(5, 0), rd); chk("R13 no alias", rd, {m_pri[3], m_pri[2], m_pri[1], m_pri[0]});

    // forwarding setup: line 40 level to cpu1, line 41 edge to cpu0
    bus_wr(0, adr(0, 0), 32'h1);
    bus_rd(0, adr(0, 0), rd); chk("R8 control readback", rd, 1);
    bus_wr(0, adr(6, 10), 32'h0000_0102);
    bus_wr(0, adr(7, 2), 32'h0008_0000);
    bus_wr(0, adr(1, 1), 32'h0000_0300);

    // R9 / R12 level line
    shared_irq[8] = 1; settle();
    chk("R12 level forward", 32'(cpu_irq), 32'b10);
    bus_rd(0, adr(3, 1), rd); chk("R9 level pending", rd & 32'h300, 32'h100);
    shared_irq[8] = 0; settle();
    chk("R12 level drop", 32'(cpu_irq), 0);
    bus_rd(0, adr(4, 1), rd); chk("R9 level released", rd & 32'h300, 0);

    // R9 edge line latches
    shared_irq[9] = 1; @(negedge clk); shared_irq[9] = 0; settle();
    chk("R12 edge forward", 32'(cpu_irq), 32'b01);
    bus_rd(1, adr(3, 1), rd); chk("R9 edge latched", rd & 32'h300, 32'h200);
    bus_wr(0, adr(4, 1), 32'h200); settle();
    chk("R9 cleared output", 32'(cpu_irq), 0);
    bus_rd(0, adr(3, 1), rd); chk("R9 cleared pending", rd & 32'h300, 0);

    // R8 forward switch
    bus_wr(0, adr(3, 1), 32'h200); settle();
    chk("R9 set view", 32'(cpu_irq), 32'b01);
    bus_wr(1, adr(0, 0), 32'h0); @(negedge clk);
    chk("R8 gated", 32'(cpu_irq), 0);
    bus_rd(0, adr(3, 1), rd); chk("R8 pending kept", rd & 32'h300, 32'h200);
    bus_wr(0, adr(0, 0), 32'h1); settle();
    chk("R8 reopened", 32'(cpu_irq), 32'b01);

    // R10 edge and clear in the same clock
    bus_valid = 1; bus_write = 1; bus_cpu = 0; bus_addr = adr(4, 1); bus_wdata = 32'h200;
    shared_irq[9] = 1;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    bus_rd(0, adr(3, 1), rd); chk("R10 edge beats clear", rd & 32'h300, 32'h200);
    shared_irq[9] = 0;
    bus_wr(0, adr(4, 1), 32'h200);
    bus_rd(0, adr(3, 1), rd); chk("R10 plain clear", rd & 32'h300, 0);
    settle();
    chk("R10 output idle", 32'(cpu_irq), 0);

    // R11 banking of private lines
    bus_wr(0, adr(1, 0), 32'h0010_0000);
    local_irq[20] = 1; local_irq[52] = 1; settle();
    chk("R11 private forward", 32'(cpu_irq), 32'b01);
    bus_rd(1, adr(1, 0), rd); chk("R11 cpu1 enables", rd, 0);
    bus_rd(1, adr(3, 0), rd); chk("R11 cpu1 own input", rd, 32'h0010_0000);
    local_irq[20] = 0; settle();
    chk("R11 cpu0 dropped", 32'(cpu_irq), 0);
    bus_wr(1, adr(3, 0), 32'h20);
    bus_rd(0, adr(3, 0), rd); chk("R11 cpu0 untouched", rd, 0);
    bus_rd(1, adr(3, 0), rd); chk("R11 cpu1 set", rd, 32'h0010_0020);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule